// File: doc/BRIEF.md
# Configurable Function-Unit Matrix

This block is a combinational compute array that evaluates a small dataflow graph in one pass. Four 32-bit operands enter at the top, a configuration word selects what every function unit does and where its two operands come from, and two 32-bit results leave at the bottom. The array is triangular and heterogeneous. From top to bottom it has a row of six arithmetic units, a row of four logic-only units, a row of three arithmetic units and a row of two logic-only units. Each unit sees only the outputs of the row directly above it.

A host pipeline treats the array as one more execution unit. It presents the operands and a configuration word, and it takes the results after the combinational delay. The main result always comes from the first unit of the bottom row. The auxiliary result can be taken from any single unit in the array, or forced to zero.

Top module: `cfa_matrix`

## Requirements
- R1: The configuration word is packed from bit 0 upward: top row first, and within a row unit 0 first. Each unit holds a 4-bit opcode in its lowest bits, then its port-A select, then its port-B select. The select widths are 2, 3, 2 and 2 bits for the rows of 6, 4, 3 and 2 units. In the first row, select values 0..3 pick op_a, op_b, op_c and op_d. In the other rows, select value k picks unit k of the row above.
- R2: res_main equals the output of unit 0 of the bottom row.
- R3: res_tap is selected by cfg[131:128]. Value 0 drives zero. Value k in 1..15 drives unit k-1, with units numbered from 0 in row-major order from the top (so 14 is the res_main unit and 15 is the second bottom unit).
- R4: In arithmetic rows (rows 0 and 2), opcode 8 gives A+B and opcode 9 gives A-B, both modulo 2^32.
- R5: In arithmetic rows, opcode 10 gives 1 when A is less than B as signed two's-complement values, and 0 otherwise.
- R6: In every row, opcode 0 passes A, 1 gives A AND B, 2 gives A OR B, 3 gives A XOR B, and 4 gives NOT A.
- R7: In every row, opcode 5 sign-extends A[7:0] and opcode 6 sign-extends A[15:0] to 32 bits.
- R8: In every row, opcode 11 zero-extends the field A[7:0] and opcode 12 zero-extends A[15:0].
- R9: Opcodes 13..15 in any row, and opcodes 8..10 in a logic-only row (rows 1 and 3), act as a pass of A.
- R10: A select value at or beyond the number of sources of its row (value 3 in the bottom row) picks source 0.
- R11: The block holds no state. Both results follow any change of operands or configuration with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | External operand, source 0 of the first row |
| op_b | input | 32 | External operand, source 1 of the first row |
| op_c | input | 32 | External operand, source 2 of the first row |
| op_d | input | 32 | External operand, source 3 of the first row |
| cfg | input | 132 | Opcodes and operand selects for all units, plus the result-tap field |
| res_main | output | 32 | Output of the first unit of the bottom row |
| res_tap | output | 32 | Output of the tapped unit, or zero |

## Verification
The array holds no state, so a bad opcode decode or a misrouted select shows at the ports in the same evaluation. It appears only if the faulty unit lies on a path to res_main or is tapped. The bench therefore sweeps the tap across all fifteen units, so every unit output is seen directly. It also drives thousands of pseudo-random configurations through a graph model, where one wrong operand or opcode changes the result. Directed cases cover the signed compare, wrap-around, the extensions, undefined opcodes in both row kinds and the out-of-range bottom-row select.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    localparam int N_IN   = 4;
    localparam int N_ROWS = 4;
    localparam int OPC_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_MOV    = 4'd0,
        OP_AND    = 4'd1,
        OP_OR     = 4'd2,
        OP_XOR    = 4'd3,
        OP_NOT    = 4'd4,
        OP_SEXT8  = 4'd5,
        OP_SEXT16 = 4'd6,
        OP_ADD    = 4'd8,
        OP_SUB    = 4'd9,
        OP_CMP    = 4'd10,
        OP_ZEXT8  = 4'd11,
        OP_ZEXT16 = 4'd12
    } fu_op_e;

    function automatic int row_units(input int r);
        case (r)
            0:       return 6;
            1:       return 4;
            2:       return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int row_arith(input int r);
        return ((r % 2) == 0) ? 1 : 0;
    endfunction

    function automatic int row_srcs(input int r);
        return (r == 0) ? N_IN : row_units(r - 1);
    endfunction

    function automatic int sel_w(input int r);
        return $clog2(row_srcs(r));
    endfunction

    function automatic int unit_cfg_w(input int r);
        return OPC_W + 2 * sel_w(r);
    endfunction

    function automatic int row_cfg_w(input int r);
        return row_units(r) * unit_cfg_w(r);
    endfunction

    function automatic int row_cfg_base(input int r);
        int acc;
        acc = 0;
        for (int k = 0; k < r; k++) acc += row_cfg_w(k);
        return acc;
    endfunction

    function automatic int unit_base(input int r);
        int acc;
        acc = 0;
        for (int k = 0; k < r; k++) acc += row_units(k);
        return acc;
    endfunction

    function automatic int max_sel_w();
        int m;
        m = 1;
        for (int k = 0; k < N_ROWS; k++) if (sel_w(k) > m) m = sel_w(k);
        return m;
    endfunction

    localparam int TOTAL_UNITS = unit_base(N_ROWS);
    localparam int TAP_W       = $clog2(TOTAL_UNITS + 1);
    localparam int ARRAY_CFG_W = row_cfg_base(N_ROWS);
    localparam int CFG_W       = ARRAY_CFG_W + TAP_W;
    localparam int SEL_MAX     = max_sel_w();

    typedef struct packed {
        logic [SEL_MAX-1:0] sel_b;
        logic [SEL_MAX-1:0] sel_a;
        fu_op_e             op;
    } unit_cfg_t;

endpackage

// File: rtl/cfa_unit.sv
module cfa_unit
    import cfa_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NSRC  = 4,
    parameter int ARITH = 1
) (
    input  logic [NSRC*WIDTH-1:0] src,
    input  unit_cfg_t             ucfg,
    output logic [WIDTH-1:0]      y
);

    logic [WIDTH-1:0] opnd_a;
    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] arith_y;
    logic             arith_hit;

    // operand selection; out-of-range selects fall back to source 0
    always_comb begin
        opnd_a = src[WIDTH-1:0];
        opnd_b = src[WIDTH-1:0];
        for (int i = 1; i < NSRC; i++) begin
            if (int'(ucfg.sel_a) == i) opnd_a = src[i*WIDTH +: WIDTH];
            if (int'(ucfg.sel_b) == i) opnd_b = src[i*WIDTH +: WIDTH];
        end
    end

    always_comb begin
        case (ucfg.op)
            OP_AND:    logic_y = opnd_a & opnd_b;
            OP_OR:     logic_y = opnd_a | opnd_b;
            OP_XOR:    logic_y = opnd_a ^ opnd_b;
            OP_NOT:    logic_y = ~opnd_a;
            OP_SEXT8:  logic_y = {{(WIDTH-8){opnd_a[7]}}, opnd_a[7:0]};
            OP_SEXT16: logic_y = {{(WIDTH-16){opnd_a[15]}}, opnd_a[15:0]};
            OP_ZEXT8:  logic_y = {{(WIDTH-8){1'b0}}, opnd_a[7:0]};
            OP_ZEXT16: logic_y = {{(WIDTH-16){1'b0}}, opnd_a[15:0]};
            default:   logic_y = opnd_a;
        endcase
    end

    generate
        if (ARITH != 0) begin : g_arith
            always_comb begin
                arith_hit = 1'b1;
                arith_y   = '0;
                case (ucfg.op)
                    OP_ADD:  arith_y = opnd_a + opnd_b;
                    OP_SUB:  arith_y = opnd_a - opnd_b;
                    OP_CMP:  arith_y[0] = ($signed(opnd_a) < $signed(opnd_b));
                    default: arith_hit = 1'b0;
                endcase
            end
        end else begin : g_logic_only
            assign arith_hit = 1'b0;
            assign arith_y   = '0;
        end
    endgenerate

    assign y = arith_hit ? arith_y : logic_y;

endmodule

// File: rtl/cfa_row.sv
module cfa_row
    import cfa_pkg::*;
#(
    parameter  int WIDTH = 32,
    parameter  int ROW   = 0,
    localparam int NSRC  = row_srcs(ROW),
    localparam int NU    = row_units(ROW),
    localparam int SW    = sel_w(ROW),
    localparam int UCW   = unit_cfg_w(ROW),
    localparam int RCW   = row_cfg_w(ROW)
) (
    input  logic [NSRC*WIDTH-1:0] src,
    input  logic [RCW-1:0]        rcfg,
    output logic [NU*WIDTH-1:0]   dout
);

    for (genvar u = 0; u < NU; u++) begin : g_unit
        unit_cfg_t uc;

        always_comb begin
            uc           = '0;
            uc.op        = fu_op_e'(rcfg[u*UCW +: OPC_W]);
            uc.sel_a[SW-1:0] = rcfg[u*UCW + OPC_W +: SW];
            uc.sel_b[SW-1:0] = rcfg[u*UCW + OPC_W + SW +: SW];
        end

        cfa_unit #(
            .WIDTH(WIDTH),
            .NSRC (NSRC),
            .ARITH(row_arith(ROW))
        ) u_fu (
            .src (src),
            .ucfg(uc),
            .y   (dout[u*WIDTH +: WIDTH])
        );
    end

endmodule

// File: rtl/cfa_tap.sv
module cfa_tap
    import cfa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [TOTAL_UNITS*WIDTH-1:0] all_y,
    input  logic [TAP_W-1:0]             tap,
    output logic [WIDTH-1:0]             y
);

    always_comb begin
        y = '0;
        for (int i = 0; i < TOTAL_UNITS; i++) begin
            if (int'(tap) == i + 1) y = all_y[i*WIDTH +: WIDTH];
        end
    end

endmodule

// File: rtl/cfa_matrix.sv
module cfa_matrix
    import cfa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] op_c,
    input  logic [WIDTH-1:0] op_d,
    input  logic [CFG_W-1:0] cfg,
    output logic [WIDTH-1:0] res_main,
    output logic [WIDTH-1:0] res_tap
);

    logic [N_IN*WIDTH-1:0]        in_bus;
    logic [TOTAL_UNITS*WIDTH-1:0] all_y;

    assign in_bus = {op_d, op_c, op_b, op_a};

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        localparam int NS  = row_srcs(r);
        localparam int NU  = row_units(r);
        localparam int BU  = unit_base(r);
        localparam int CB  = row_cfg_base(r);
        localparam int CWR = row_cfg_w(r);

        logic [NS*WIDTH-1:0] src;

        if (r == 0) begin : g_first
            assign src = in_bus;
        end else begin : g_next
            assign src = all_y[unit_base(r-1)*WIDTH +: NS*WIDTH];
        end

        cfa_row #(
            .WIDTH(WIDTH),
            .ROW  (r)
        ) u_row (
            .src (src),
            .rcfg(cfg[CB +: CWR]),
            .dout(all_y[BU*WIDTH +: NU*WIDTH])
        );
    end

    assign res_main = all_y[unit_base(N_ROWS-1)*WIDTH +: WIDTH];

    cfa_tap #(
        .WIDTH(WIDTH)
    ) u_tap (
        .all_y(all_y),
        .tap  (cfg[CFG_W-1 -: TAP_W]),
        .y    (res_tap)
    );

endmodule

// File: rtl/cfa_matrix_chk.sv
module cfa_matrix_chk
    import cfa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] op_c,
    input logic [WIDTH-1:0] op_d,
    input logic [CFG_W-1:0] cfg,
    input logic [WIDTH-1:0] res_main,
    input logic [WIDTH-1:0] res_tap
);

    localparam int BOT_CB  = row_cfg_base(N_ROWS-1);
    localparam int BOT_UCW = unit_cfg_w(N_ROWS-1);

    logic [TAP_W-1:0] tap_f;
    logic [OPC_W-1:0] bot0_op;
    logic [OPC_W-1:0] bot1_op;
    logic             known;

    assign tap_f   = cfg[CFG_W-1 -: TAP_W];
    assign bot0_op = cfg[BOT_CB +: OPC_W];
    assign bot1_op = cfg[BOT_CB + BOT_UCW +: OPC_W];
    assign known   = !$isunknown({op_a, op_b, op_c, op_d, cfg, res_main, res_tap});

    always_comb begin
        if (known) begin
            assert_tap_none_R3: assert (!(tap_f == '0) || (res_tap == '0))
                else $error("tap field zero but auxiliary result nonzero");
            assert_tap_main_R2: assert (!(int'(tap_f) == TOTAL_UNITS - 1) || (res_tap == res_main))
                else $error("tap of bottom unit 0 differs from main result");
            assert_sext8_R7: assert (!(bot0_op == 4'(OP_SEXT8)) ||
                                     (&res_main[WIDTH-1:7]) || !(|res_main[WIDTH-1:7]))
                else $error("byte sign extension not uniform");
            assert_zext16_R8: assert (!(int'(tap_f) == TOTAL_UNITS && bot1_op == 4'(OP_ZEXT16)) ||
                                      (res_tap[WIDTH-1:16] == '0))
                else $error("halfword zero extension leaked upper bits");
        end
    end

endmodule

bind cfa_matrix cfa_matrix_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_cfa_matrix.sv
module sim_cfa_matrix;

    localparam int CLK_PERIOD = 10;
    localparam int BCFG_W     = 132;

    logic clk;
    logic rst;
    logic [31:0] op_a, op_b, op_c, op_d;
    logic [BCFG_W-1:0] cfg;
    logic [31:0] res_main, res_tap;

    int checks;
    int errors;
    bit done;

    int op_m [4][6];
    int sa_m [4][6];
    int sb_m [4][6];
    int tap_m;
    logic [31:0] v [4][6];
    logic [31:0] exp_main, exp_tap;
    logic [31:0] seed;

    int N_UNITS [4] = '{6, 4, 3, 2};
    int N_SRC   [4] = '{4, 6, 4, 3};
    int S_W     [4] = '{2, 3, 2, 2};

    cfa_matrix u0 (
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .cfg(cfg), .res_main(res_main), .res_tap(res_tap)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] fu_model(int r, int op, logic [31:0] a, logic [31:0] b);
        bit ar;
        ar = (r == 0) || (r == 2);
        case (op)
            1:  return a & b;
            2:  return a | b;
            3:  return a ^ b;
            4:  return ~a;
            5:  return {{24{a[7]}}, a[7:0]};
            6:  return {{16{a[15]}}, a[15:0]};
            8:  return ar ? a + b : a;
            9:  return ar ? a - b : a;
            10: return ar ? (($signed(a) < $signed(b)) ? 32'd1 : 32'd0) : a;
            11: return {24'd0, a[7:0]};
            12: return {16'd0, a[15:0]};
            default: return a;
        endcase
    endfunction

    task automatic clear_cfg();
        for (int r = 0; r < 4; r++)
            for (int u = 0; u < 6; u++) begin
                op_m[r][u] = 0; sa_m[r][u] = 0; sb_m[r][u] = 0;
            end
        tap_m = 0;
    endtask

    task automatic pack_and_model();
        int pos;
        int sa, sb, flat;
        logic [31:0] a, b;
        pos = 0;
        cfg = '0;
        for (int r = 0; r < 4; r++)
            for (int u = 0; u < N_UNITS[r]; u++) begin
                for (int k = 0; k < 4; k++) cfg[pos + k] = op_m[r][u][k];
                pos += 4;
                for (int k = 0; k < S_W[r]; k++) cfg[pos + k] = sa_m[r][u][k];
                pos += S_W[r];
                for (int k = 0; k < S_W[r]; k++) cfg[pos + k] = sb_m[r][u][k];
                pos += S_W[r];
            end
        for (int k = 0; k < 4; k++) cfg[128 + k] = tap_m[k];
        for (int r = 0; r < 4; r++)
            for (int u = 0; u < N_UNITS[r]; u++) begin
                sa = (sa_m[r][u] >= N_SRC[r]) ? 0 : sa_m[r][u];
                sb = (sb_m[r][u] >= N_SRC[r]) ? 0 : sb_m[r][u];
                if (r == 0) begin
                    a = (sa == 0) ? op_a : (sa == 1) ? op_b : (sa == 2) ? op_c : op_d;
                    b = (sb == 0) ? op_a : (sb == 1) ? op_b : (sb == 2) ? op_c : op_d;
                end else begin
                    a = v[r-1][sa];
                    b = v[r-1][sb];
                end
                v[r][u] = fu_model(r, op_m[r][u], a, b);
            end
        exp_main = v[3][0];
        exp_tap  = 32'd0;
        flat = 0;
        for (int r = 0; r < 4; r++)
            for (int u = 0; u < N_UNITS[r]; u++) begin
                flat++;
                if (flat == tap_m) exp_tap = v[r][u];
            end
    endtask

    task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_case(string req);
        @(posedge clk);
        #1;
        pack_and_model();
        #(CLK_PERIOD/4);
        check_val(req, res_main, exp_main);
        check_val(req, res_tap, exp_tap);
    endtask

    // route row0 unit 5 straight down to res_main
    task automatic route_from_r0u5();
        sa_m[1][0] = 5;
        sa_m[2][0] = 0;
        sa_m[3][0] = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; done = 0;
        seed = 32'h1234_5678;
        rst = 1'b1;
        op_a = 32'h0000_0011; op_b = 32'h0000_0022; op_c = 32'h0000_0033; op_d = 32'h0000_0044;
        cfg = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // all-zero configuration: every unit passes port A from source 0
        #1;
        check_val("R1 zero cfg main", res_main, 32'h0000_0011);
        check_val("R3 zero tap", res_tap, 32'd0);

        // R4: addition wraps
        clear_cfg(); op_a = 32'hFFFF_FFFF; op_b = 32'h0000_0001;
        op_m[0][5] = 8; sa_m[0][5] = 0; sb_m[0][5] = 1; route_from_r0u5(); tap_m = 6;
        run_case("R4 add wrap");
        check_val("R4 add wrap literal", res_main, 32'd0);

        // R4: subtraction wraps
        clear_cfg(); op_a = 32'd0; op_b = 32'd1;
        op_m[0][5] = 9; sa_m[0][5] = 0; sb_m[0][5] = 1; route_from_r0u5();
        run_case("R4 sub wrap");
        check_val("R4 sub literal", res_main, 32'hFFFF_FFFF);

        // R5: signed compare, both directions and equality
        clear_cfg(); op_a = 32'hFFFF_FFFF; op_b = 32'd1;
        op_m[0][5] = 10; sa_m[0][5] = 0; sb_m[0][5] = 1; route_from_r0u5();
        run_case("R5 cmp neg<pos");
        check_val("R5 cmp literal 1", res_main, 32'd1);
        sa_m[0][5] = 1; sb_m[0][5] = 0;
        run_case("R5 cmp pos<neg");
        check_val("R5 cmp literal 0", res_main, 32'd0);
        sb_m[0][5] = 1;
        run_case("R5 cmp equal");

        // R7 / R8: extensions in a logic row (row 1)
        clear_cfg(); op_c = 32'h1234_8081;
        sa_m[0][2] = 2; op_m[1][2] = 5; sa_m[1][2] = 2; tap_m = 9;
        sa_m[2][0] = 2; sa_m[3][0] = 0;
        run_case("R7 sext8");
        check_val("R7 sext8 literal", res_main, 32'hFFFF_FF81);
        op_m[1][2] = 6; run_case("R7 sext16");
        op_m[1][2] = 11; run_case("R8 zext8");
        op_m[1][2] = 12; run_case("R8 zext16");
        check_val("R8 zext16 literal", res_main, 32'h0000_8081);

        // R9: arithmetic opcodes in logic rows, undefined opcodes anywhere
        clear_cfg(); op_a = 32'h0000_0100; op_b = 32'h0000_0200;
        sb_m[0][0] = 1; op_m[1][0] = 8; sb_m[1][0] = 0;
        op_m[2][0] = 14; op_m[3][0] = 10; sa_m[3][0] = 0; sb_m[3][0] = 1; tap_m = 15;
        run_case("R9 undefined pass");
        check_val("R9 pass literal", res_main, 32'h0000_0100);

        // R10: bottom-row select value 3 picks source 0
        clear_cfg(); op_a = 32'hA5A5_0001;
        op_m[2][0] = 4; op_m[2][1] = 0;
        sa_m[3][0] = 3; tap_m = 14;
        run_case("R10 out-of-range select");
        check_val("R10 literal", res_main, 32'h5A5A_FFFE);

        // R6: logic functions in row 3
        for (int op = 0; op <= 4; op++) begin
            clear_cfg(); op_a = 32'hF0F0_1234; op_b = 32'h0FF0_4321;
            sa_m[0][1] = 1; sa_m[2][1] = 1;
            op_m[3][0] = op; sa_m[3][0] = 0; sb_m[3][0] = 1; tap_m = 14;
            run_case("R6 logic op");
        end

        // R3: tap sweep across every unit under a random graph
        for (int t = 0; t <= 15; t++) begin
            clear_cfg();
            op_a = rnd(); op_b = rnd(); op_c = rnd(); op_d = rnd();
            for (int r = 0; r < 4; r++)
                for (int u = 0; u < N_UNITS[r]; u++) begin
                    op_m[r][u] = int'(rnd() % 16);
                    sa_m[r][u] = int'(rnd() % (1 << S_W[r]));
                    sb_m[r][u] = int'(rnd() % (1 << S_W[r]));
                end
            tap_m = t;
            run_case("R3 tap sweep");
        end

        // R11: operand change alone updates results with no clock edge
        @(negedge clk);
        op_a = op_a ^ 32'hFFFF_FFFF;
        pack_and_model();
        #1;
        check_val("R11 no-clock update main", res_main, exp_main);
        check_val("R11 no-clock update tap", res_tap, exp_tap);

        // R1: broad pseudo-random sweep of configurations and operands
        for (int it = 0; it < 3000; it++) begin
            clear_cfg();
            op_a = rnd(); op_b = rnd(); op_c = rnd(); op_d = rnd();
            if (it % 4 == 0) begin op_a = {24'd0, op_a[7:0]}; op_b = 32'h8000_0000; end
            for (int r = 0; r < 4; r++)
                for (int u = 0; u < N_UNITS[r]; u++) begin
                    op_m[r][u] = int'(rnd() % 16);
                    sa_m[r][u] = int'(rnd() % (1 << S_W[r]));
                    sb_m[r][u] = int'(rnd() % (1 << S_W[r]));
                end
            tap_m = int'(rnd() % 16);
            run_case("R1 random graph");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule